// File: doc/BRIEF.md
# Programmable BCD divide-by-n counter

This block divides its clock by a programmable ratio n and emits one output pulse per n clocks. It is a synchronous down counter built as a mixed-radix chain. A low stage takes its modulus from the mode inputs. Three cascaded BCD decades follow it. At the top sits a small binary stage whose digit is worth thousands. The chain is loaded from a 16-bit preset bus and counts down to its terminal value. On the same edge that it reloads, it raises the output. For divide-by-n operation the ratio is n = M·(1000·T + 100·H + 10·Ts + U) + L. M is the low-stage modulus, L is the low digit, U/Ts/H are the three decades and T is the top digit.

The low preset nibble is shared between the low stage and the top stage. Whatever bits the low stage does not need go to the top stage. The mode code also selects three other behaviours. The first is a fixed divide-by-10 000 chain that ignores the preset. The second is a hold state that parks the chain. The third is a timer behaviour, in which a level input stretches the output pulse until it is released. The counter keeps running while the output is held.

Top module: `prog_divider`

## Requirements
- R1: While rst_n is low, pulse_out is low. After reset is released in a divide mode, pulse_out is first seen high after the (n+1)th rising edge.
- R2: mode_sel selects the low-stage modulus as follows: 3'b011 gives 10 (4 low bits), 3'b001 gives 8 (3 bits), 3'b110 gives 5 (3 bits), 3'b101 gives 4 (2 bits) and 3'b111 gives 2 (1 bit). 3'b010 selects the fixed divide-by-10 000 chain. 3'b000 and 3'b100 select the preset hold.
- R3: In a divide mode with hold_en low, pulse_out is high for exactly one cycle every n cycles, with n = M·(1000·T + 100·H + 10·Ts + U) + L, for any n of 3 or more.
- R4: A decade preset digit above 9 counts as 9, and a low digit above M−1 counts as M−1.
- R5: Field positions on the preset bus: U is preset[7:4], Ts is preset[11:8] and H is preset[15:12]. L is the low "low-bits" bits of preset[3:0]. T is the remaining upper bits of preset[3:0], so T ranges up to 0, 1, 1, 3 or 7 for M = 10, 8, 5, 4 or 2.
- R6: In the fixed mode, pulse_out pulses once every 10 000 cycles, whatever the preset bus holds.
- R7: While hold_en is high, pulse_out stays high once it has risen. The chain keeps counting, so later terminal counts fall on the same schedule.
- R8: In the preset-hold codes, pulse_out goes low on the next edge even when hold_en is high, and the chain is parked. After leaving the hold code for a divide mode, the first pulse is seen after the (n+1)th edge.
- R9: When hold_en is low and no terminal count occurs, a high pulse_out falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Low-stage modulus / operating mode code |
| hold_en | input | 1 | High: output stays high after a pulse (timer behaviour) |
| preset | input | 16 | Division ratio preset: low/top nibble and three BCD digits |
| pulse_out | output | 1 | Divided output pulse |

## Verification
The assertions assume that mode_sel and preset change only during reset or while the preset-hold code is applied. They also assume that every divide-mode preset encodes a ratio of at least 3, because the one-cycle pulse and the digit range checks rely on a stable modulus and a gap between terminal counts. The stimulus therefore passes through the hold code for several cycles before every new mode and preset. All table presets give n of 3 or more, including the clamped digits.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] digit_t;
  localparam digit_t DEC_MAX = 4'd9;
  typedef enum logic [1:0] {RUN_DIVIDE, RUN_FIXED, RUN_PRESET} run_kind_e;
endpackage

// File: rtl/pd_mode_decode.sv
module pd_mode_decode
  import pd_pkg::*;
(
  input  logic [2:0] mode_sel,
  input  digit_t     preset_low,
  output run_kind_e  kind,
  output digit_t     low_max,
  output digit_t     top_max,
  output digit_t     low_load,
  output digit_t     top_load
);
  logic [2:0] low_bits;
  digit_t     low_mask;

  // R2: mode code to low-stage modulus and bit split
  always_comb begin
    kind     = RUN_DIVIDE;
    low_bits = 3'd4;
    low_max  = 4'd9;
    case (mode_sel)
      3'b011: low_bits = 3'd4;
      3'b001: begin low_bits = 3'd3; low_max = 4'd7; end
      3'b110: begin low_bits = 3'd3; low_max = 4'd4; end
      3'b101: begin low_bits = 3'd2; low_max = 4'd3; end
      3'b111: begin low_bits = 3'd1; low_max = 4'd1; end
      3'b010: kind = RUN_FIXED;
      default: kind = RUN_PRESET;
    endcase
  end

  // R5: spare low-nibble bits feed the thousands stage
  assign low_mask = digit_t'((5'd1 << low_bits) - 5'd1);
  assign top_max  = digit_t'(4'hF >> low_bits);
  assign low_load = (kind == RUN_FIXED) ? DEC_MAX : (preset_low & low_mask);
  assign top_load = (kind == RUN_FIXED) ? digit_t'(0) : digit_t'(preset_low >> low_bits);
endmodule

// File: rtl/pd_digit.sv
module pd_digit
  import pd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  digit_t load_val,
  input  digit_t max_val,
  input  logic   dec_en,
  output digit_t val,
  output logic   is_zero
);
  digit_t clamped;

  // R4: out-of-range preset digits saturate at the stage maximum
  assign clamped = (load_val > max_val) ? max_val : load_val;
  assign is_zero = (val == digit_t'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val <= '0;
    else if (load)   val <= clamped;
    else if (dec_en) val <= is_zero ? max_val : val - digit_t'(1);
  end

  assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |-> (val <= max_val));

  assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_en && is_zero) |=> (val == $past(max_val)));

  assert_digit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_en && !load) |=> $stable(val));
endmodule

// File: rtl/pd_pulse_latch.sv
module pd_pulse_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic term,
  input  logic hold_en,
  input  logic preset_mode,
  output logic out_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           out_q <= 1'b0;
    else if (preset_mode) out_q <= 1'b0;
    else if (term)        out_q <= 1'b1;
    else if (hold_en)     out_q <= out_q;
    else                  out_q <= 1'b0;
  end

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && hold_en && !preset_mode) |=> out_q);

  assert_preset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preset_mode |=> !out_q);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && !hold_en && !term) |=> !out_q);
endmodule

// File: rtl/prog_divider.sv
module prog_divider
  import pd_pkg::*;
#(
  parameter int NUM_DEC = 3,
  localparam int PW = DIG_W * (NUM_DEC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          hold_en,
  input  logic [PW-1:0] preset,
  output logic          pulse_out
);
  localparam int NUM_STG = NUM_DEC + 2;
  localparam int TOP     = NUM_STG - 1;

  run_kind_e kind;
  digit_t    low_max, top_max, low_load, top_load;

  pd_mode_decode u_dec (
    .mode_sel   (mode_sel),
    .preset_low (preset[DIG_W-1:0]),
    .kind       (kind),
    .low_max    (low_max),
    .top_max    (top_max),
    .low_load   (low_load),
    .top_load   (top_load)
  );

  // first counting edge after reset or hold reloads the chain
  logic was_idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_idle <= 1'b1;
    else        was_idle <= (kind == RUN_PRESET);
  end

  digit_t             stg_val  [NUM_STG];
  digit_t             stg_max  [NUM_STG];
  digit_t             stg_load [NUM_STG];
  logic [NUM_STG-1:0] stg_zero;
  logic [NUM_STG-1:0] borrow;
  logic               chain_load;
  logic               term;
  logic               upper_zero;

  generate
    for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
      if (g == 0) begin : g_low
        assign stg_max[g]  = low_max;
        assign stg_load[g] = low_load;
      end else if (g == TOP) begin : g_top
        assign stg_max[g]  = top_max;
        assign stg_load[g] = top_load;
      end else begin : g_dec
        assign stg_max[g]  = DEC_MAX;
        assign stg_load[g] = (kind == RUN_FIXED) ? DEC_MAX : preset[g*DIG_W +: DIG_W];
      end
      if (g < TOP) begin : g_borrow
        assign borrow[g+1] = borrow[g] & stg_zero[g];
      end
      pd_digit u_digit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (chain_load),
        .load_val (stg_load[g]),
        .max_val  (stg_max[g]),
        .dec_en   (borrow[g]),
        .val      (stg_val[g]),
        .is_zero  (stg_zero[g])
      );
    end
  endgenerate

  assign upper_zero = &stg_zero[NUM_STG-1:1];

  always_comb begin
    case (kind)
      RUN_DIVIDE: term = upper_zero & (stg_val[0] <= digit_t'(1)) & !was_idle;
      RUN_FIXED:  term = upper_zero & stg_zero[0] & !was_idle;
      default:    term = 1'b0;
    endcase
  end

  // divide modes reload at the count of one; the fixed chain wraps through zero
  assign chain_load = was_idle | (kind == RUN_PRESET) | ((kind == RUN_DIVIDE) & term);
  assign borrow[0]  = !chain_load;

  pd_pulse_latch u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .term        (term),
    .hold_en     (hold_en),
    .preset_mode (kind == RUN_PRESET),
    .out_q       (pulse_out)
  );

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == RUN_DIVIDE) && !hold_en && $rose(pulse_out)) |=> !pulse_out);
endmodule

// File: tb/prog_divider_bench.sv
`timescale 1ns/1ps
module prog_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel;
  logic        hold_en;
  logic [15:0] preset;
  logic        pulse_out;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_divider u_prog_divider (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .hold_en(hold_en), .preset(preset), .pulse_out(pulse_out)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] pre;
    logic [15:0] n;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b011, 16'h0013, 16'd13},    // R2 modulus 10
    '{3'b011, 16'h0105, 16'd105},   // R5 tens digit
    '{3'b001, 16'h0021, 16'd17},    // R2 modulus 8
    '{3'b110, 16'h0034, 16'd19},    // R2 modulus 5
    '{3'b110, 16'h0017, 16'd9},     // R4 low digit 7 clamps to 4
    '{3'b101, 16'h0046, 16'd4018},  // R5 modulus 4, top digit 1
    '{3'b111, 16'h0005, 16'd4001},  // R5 modulus 2, top digit 2
    '{3'b111, 16'h0013, 16'd2003},  // R5 modulus 2, top digit 1
    '{3'b011, 16'h00F3, 16'd93},    // R4 BCD digit F clamps to 9
    '{3'b011, 16'h0003, 16'd3},     // R3 smallest ratio
    '{3'b110, 16'h695C, 16'd8479},  // R5 all fields, modulus 5
    '{3'b010, 16'h1234, 16'd10000}  // R6 fixed chain ignores preset
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // counts falling edges until pulse_out is seen high
  task automatic edges_to_high(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!pulse_out && k < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    mode_sel = 3'b011;
    hold_en  = 1'b0;
    preset   = 16'h0013;
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R1 low in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    edges_to_high(k);
    check(k == 14, "R1 first pulse after reset", k, 14);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_sel = 3'b000;
      preset   = VECS[i].pre;
      repeat (3) @(negedge clk);
      check(pulse_out == 1'b0, "R8 low in hold code", int'(pulse_out), 0);
      mode_sel = VECS[i].mode;
      edges_to_high(k);
      check(k == int'(VECS[i].n) + 1, "R8 first pulse after hold", k, int'(VECS[i].n) + 1);
      @(negedge clk);
      check(pulse_out == 1'b0, "R3 one-cycle width", int'(pulse_out), 0);
      edges_to_high(k);
      check(k + 1 == int'(VECS[i].n), "R3 R2 R5 period", k + 1, int'(VECS[i].n));
    end

    // R7 and R9: timer behaviour with n = 13
    @(negedge clk);
    mode_sel = 3'b000;
    preset   = 16'h0013;
    repeat (2) @(negedge clk);
    mode_sel = 3'b011;
    hold_en  = 1'b1;
    edges_to_high(k);
    begin
      int lows = 0;
      for (int j = 0; j < 19; j++) begin
        @(negedge clk);
        if (!pulse_out) lows++;
      end
      check(lows == 0, "R7 output held high", lows, 0);
    end
    hold_en = 1'b0;
    @(negedge clk);
    check(pulse_out == 1'b0, "R9 falls after release", int'(pulse_out), 0);
    edges_to_high(k);
    check(k == 6, "R7 count kept advancing", k, 6);

    // R8: hold code clears a latched output
    hold_en = 1'b1;
    edges_to_high(k);
    mode_sel = 3'b100;
    @(negedge clk);
    check(pulse_out == 1'b0, "R8 hold code clears latch", int'(pulse_out), 0);
    hold_en  = 1'b0;
    mode_sel = 3'b011;

    // R1: asynchronous reset forces the output low
    edges_to_high(k);
    rst_n = 1'b0;
    #1;
    check(pulse_out == 1'b0, "R1 async reset", int'(pulse_out), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule